// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Controller

This block runs one access at a time to an asynchronous static memory or peripheral that sits on a multiplexed address/data local bus. A request arrives with an address, a read or write direction, per-byte lane enables and write data. The block then plays out a fixed sequence of phases. First comes an address phase marked by an address latch enable. Next is an optional chip-select setup gap. Then comes a data strobe phase, stretched by wait states. For writes there is also an optional hold cycle.

Configuration inputs set several things: the number of wait states, a relaxed-timing mode that doubles that number, an extended chip-select setup, early negation of the write strobe, and whether an external transfer acknowledge may cut the strobe short. The configuration and the request are both captured when the request is accepted. Each access ends with a one-cycle completion pulse. Read data is captured on the last strobe cycle.

Top module: `smc_bank_ctrl`

## Requirements
- R1: After reset, `cs_n`=1, `oe_n`=1, `we_n`=all ones, `ale`=0, `ad_oe`=0, `done`=0 and `req_ready`=1.
- R2: An accepted request gives, in the next cycle (cycle 0 of the access), exactly one cycle of `ale`=1. In that cycle `ad_oe`=1 and `ad_out` carries the request address, zero-extended. `ale` is never high again in the access.
- R3: `cs_n` first goes low in cycle 1 when `cfg_cs_setup`=0. When `cfg_cs_setup`=1 it first goes low in cycle 2, or in cycle 3 if `cfg_relax`=1 as well. `cs_n` is high during the address cycle and the setup gap.
- R4: With no early acknowledge, the strobe phase lasts W+1 cycles. W equals `cfg_wait` when `cfg_relax`=0, or 2×`cfg_wait` when `cfg_relax`=1. With the default 4-bit field, W ranges from 0 to 30.
- R5: On a read (`req_write`=0), `oe_n` is low in every strobe cycle, `we_n` stays all ones, and `ad_oe` is 0 after cycle 0.
- R6: On a write, `we_n[i]` is low in every strobe cycle exactly when `req_be[i]`=1. Bit i of `we_n` and of `req_be` is byte lane i. `oe_n` stays high, and `ad_out` carries the write data with `ad_oe`=1.
- R7: When `cfg_ext_ack`=1, raising `ack_in` in access cycle j makes the access act on it in cycle j+2, through a two-stage synchronizer. If cycle j+2 or a later cycle is a strobe cycle before the counter would expire, the strobe ends there. If the acknowledge is already seen before the strobe starts, the strobe lasts one cycle.
- R8: When `cfg_ext_ack`=0, `ack_in` has no effect, and the strobe runs its full W+1 cycles.
- R9: On a write with `cfg_we_early`=1, `cs_n` stays low for one extra cycle after the last strobe cycle, with `we_n` all ones. In every other case `cs_n` rises together with the strobe.
- R10: `done` is high for exactly one cycle: the first cycle after `cs_n` returns high. On a read, `rd_data` then holds the `ad_in` value present in the last strobe cycle.
- R11: `req_ready` is low from cycle 0 of an access until the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wait | input | WAIT_W | Programmed wait-state count |
| cfg_relax | input | 1 | Relaxed timing: doubles wait states, lengthens CS setup |
| cfg_cs_setup | input | 1 | Extended chip-select setup after the address phase |
| cfg_ext_ack | input | 1 | 1 allows external acknowledge to end the strobe |
| cfg_we_early | input | 1 | Negate write strobe one cycle before chip select |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW | Access address |
| req_be | input | DW/8 | Byte lane enables |
| req_wdata | input | DW | Write data |
| ack_in | input | 1 | External transfer acknowledge (asynchronous) |
| ale | output | 1 | Address latch enable |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | DW/8 | Per-lane write enables, active low |
| ad_out | output | DW | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | DW | Multiplexed data in |
| rd_data | output | DW | Captured read data |
| done | output | 1 | One-cycle access completion |

## Verification
The bench builds the block with its default parameters: a 32-bit data bus with four byte lanes, a 16-bit address and a 4-bit wait field. This brings the full 0 to 30 wait range within reach, including the longest strobe of 31 cycles under relaxed timing. During reads, the bench drives `ad_in` with a value that changes every cycle, so a capture one cycle early or late shows up. The acknowledge cases place the raw edge before the strobe, inside it, and after the counter would expire. They also cover the case with the acknowledge disabled.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_GAP,
        ST_STRB,
        ST_HOLD
    } smc_state_e;

    typedef struct packed {
        logic relax;
        logic cs_setup;
        logic ext_ack;
        logic we_early;
    } smc_cfg_t;

    // Number of idle cycles between the address cycle and chip-select assertion.
    function automatic logic [1:0] gap_cycles(input logic cs_setup, input logic relax);
        if (!cs_setup)
            return 2'd0;
        else if (relax)
            return 2'd2;
        else
            return 2'd1;
    endfunction

endpackage

// File: rtl/smc_ack_sync.sv
module smc_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_raw,
    output logic ack_sync
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else
            sr <= {sr[STAGES-2:0], ack_raw};
    end

    assign ack_sync = sr[STAGES-1];

    // R7: synchronized output follows the raw input with a fixed lag.
    assert_sync_lag_R7: assert property (@(posedge clk) disable iff (rst)
        sr[0] |=> (sr[1] == $past(sr[0])));
endmodule

// File: rtl/smc_down_ctr.sv
module smc_down_ctr #(
    parameter int CW   = 5,
    parameter int MAXV = 30
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          dec,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] count,
    output logic          zero
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (dec)
            count <= count - 1'b1;
    end

    assign zero = (count == '0);

    // R4: the counter never wraps below zero.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
        dec |-> !zero);
    // R4: loaded values stay inside the legal wait range.
    assert_bound_R4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(MAXV));
endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_fire,
    input  logic       wr,
    input  logic       we_early,
    input  logic       ext_en,
    input  logic       ack_s,
    input  logic [1:0] gap_len,
    input  logic       gap_zero,
    input  logic       wait_zero,
    output smc_state_e state,
    output logic       gap_load,
    output logic       gap_dec,
    output logic       wait_load,
    output logic       wait_dec,
    output logic       term,
    output logic       finish
);
    smc_state_e nxt;
    logic       hold_needed;

    assign hold_needed = wr && we_early;
    assign term        = (state == ST_STRB) && (wait_zero || (ext_en && ack_s));
    assign gap_load    = (state == ST_ADDR) && (gap_len != 2'd0);
    assign gap_dec     = (state == ST_GAP) && !gap_zero;
    assign wait_load   = ((state == ST_ADDR) && (gap_len == 2'd0)) ||
                         ((state == ST_GAP) && gap_zero);
    assign wait_dec    = (state == ST_STRB) && !wait_zero;
    assign finish      = (term && !hold_needed) || (state == ST_HOLD);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_fire) nxt = ST_ADDR;
            ST_ADDR: nxt = (gap_len != 2'd0) ? ST_GAP : ST_STRB;
            ST_GAP:  if (gap_zero) nxt = ST_STRB;
            ST_STRB: if (term) nxt = hold_needed ? ST_HOLD : ST_IDLE;
            ST_HOLD: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // R8: with the acknowledge disabled, a nonzero counter keeps the strobe going.
    assert_ext_off_full_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STRB && !ext_en && !wait_zero) |=> (state == ST_STRB));
    // R9: the write hold phase lasts one cycle.
    assert_hold_once_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |=> (state == ST_IDLE));
    // R2: the address phase lasts one cycle.
    assert_addr_once_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ADDR) |=> (state != ST_ADDR));
endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
    import smc_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 32,
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              cfg_relax,
    input  logic              cfg_cs_setup,
    input  logic              cfg_ext_ack,
    input  logic              cfg_we_early,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW/8-1:0]   req_be,
    input  logic [DW-1:0]     req_wdata,
    input  logic              ack_in,
    output logic              ale,
    output logic              cs_n,
    output logic              oe_n,
    output logic [DW/8-1:0]   we_n,
    output logic [DW-1:0]     ad_out,
    output logic              ad_oe,
    input  logic [DW-1:0]     ad_in,
    output logic [DW-1:0]     rd_data,
    output logic              done
);
    localparam int NLANE = DW / 8;
    localparam int CW    = WAIT_W + 1;
    localparam int MAXW  = 2 * ((1 << WAIT_W) - 1);

    smc_state_e          state;
    smc_cfg_t            cap_cfg;
    logic [WAIT_W-1:0]   cap_wait;
    logic                cap_wr;
    logic [AW-1:0]       cap_addr;
    logic [NLANE-1:0]    cap_be;
    logic [DW-1:0]       cap_wdata;
    logic                ack_s;
    logic [1:0]          gap_len;
    logic                gap_load, gap_dec, gap_zero;
    logic                wait_load, wait_dec, wait_zero;
    logic [CW-1:0]       gap_cnt, wait_cnt, wait_total, gap_start;
    logic                term, finish, req_fire;
    logic                strobing;

    assign req_ready = (state == ST_IDLE);
    assign req_fire  = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_cfg   <= '0;
            cap_wait  <= '0;
            cap_wr    <= 1'b0;
            cap_addr  <= '0;
            cap_be    <= '0;
            cap_wdata <= '0;
        end else if (req_fire) begin
            cap_cfg   <= '{relax: cfg_relax, cs_setup: cfg_cs_setup,
                           ext_ack: cfg_ext_ack, we_early: cfg_we_early};
            cap_wait  <= cfg_wait;
            cap_wr    <= req_write;
            cap_addr  <= req_addr;
            cap_be    <= req_be;
            cap_wdata <= req_wdata;
        end
    end

    assign gap_len    = gap_cycles(cap_cfg.cs_setup, cap_cfg.relax);
    assign gap_start  = CW'(gap_len) - 1'b1;
    assign wait_total = cap_cfg.relax ? {cap_wait, 1'b0} : {1'b0, cap_wait};

    smc_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .ack_raw  (ack_in),
        .ack_sync (ack_s)
    );

    smc_down_ctr #(.CW(CW), .MAXV(2)) u_gap_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .dec      (gap_dec),
        .load_val (gap_start),
        .count    (gap_cnt),
        .zero     (gap_zero)
    );

    smc_down_ctr #(.CW(CW), .MAXV(MAXW)) u_wait_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .dec      (wait_dec),
        .load_val (wait_total),
        .count    (wait_cnt),
        .zero     (wait_zero)
    );

    smc_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .wr        (cap_wr),
        .we_early  (cap_cfg.we_early),
        .ext_en    (cap_cfg.ext_ack),
        .ack_s     (ack_s),
        .gap_len   (gap_len),
        .gap_zero  (gap_zero),
        .wait_zero (wait_zero),
        .state     (state),
        .gap_load  (gap_load),
        .gap_dec   (gap_dec),
        .wait_load (wait_load),
        .wait_dec  (wait_dec),
        .term      (term),
        .finish    (finish)
    );

    // Bus pin decode from the registered phase.
    assign strobing = (state == ST_STRB);
    assign ale      = (state == ST_ADDR);
    assign cs_n     = !(strobing || state == ST_HOLD);
    assign oe_n     = !(strobing && !cap_wr);

    generate
        for (genvar i = 0; i < NLANE; i++) begin : g_lane
            assign we_n[i] = !(strobing && cap_wr && cap_be[i]);
        end
    endgenerate

    assign ad_oe  = ale || (cap_wr && state != ST_IDLE);
    assign ad_out = ale ? DW'(cap_addr) : cap_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= finish;
            if (term && !cap_wr)
                rd_data <= ad_in;
        end
    end

    // R2: latch enable is a single-cycle pulse.
    assert_ale_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);
    // R3: chip select is never active in the address cycle.
    assert_cs_after_ale_R3: assert property (@(posedge clk) disable iff (rst)
        ale |-> cs_n);
    // R5: any data strobe sits inside an active chip select.
    assert_strobe_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
        (!oe_n || we_n != '1) |-> !cs_n);
    // R6: read and write strobes never overlap.
    assert_oe_we_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && we_n != '1));
    // R10: completion is a single-cycle pulse following chip-select release.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_after_cs_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> done);
    // R11: no new request is accepted while an access runs.
    assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !done) |=> $stable(cap_addr));
endmodule

// File: tb/tb_smc_bank_ctrl.sv
module tb_smc_bank_ctrl;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int WW = 4;
    localparam int NL = DW / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [WW-1:0] cfg_wait;
    logic          cfg_relax, cfg_cs_setup, cfg_ext_ack, cfg_we_early;
    logic          req_valid, req_ready, req_write;
    logic [AW-1:0] req_addr;
    logic [NL-1:0] req_be;
    logic [DW-1:0] req_wdata;
    logic          ack_in;
    logic          ale, cs_n, oe_n, ad_oe, done;
    logic [NL-1:0] we_n;
    logic [DW-1:0] ad_out, ad_in, rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    smc_bank_ctrl #(.AW(AW), .DW(DW), .WAIT_W(WW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cfg_wait(cfg_wait), .cfg_relax(cfg_relax),
        .cfg_cs_setup(cfg_cs_setup), .cfg_ext_ack(cfg_ext_ack),
        .cfg_we_early(cfg_we_early), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .ack_in(ack_in), .ale(ale), .cs_n(cs_n),
        .oe_n(oe_n), .we_n(we_n), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .rd_data(rd_data), .done(done)
    );

    function automatic logic [DW-1:0] pat(input int k);
        return 32'hC0DE_0000 + DW'(k);
    endfunction

    task automatic chk(input string rq, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // One access; expected timing derived from the requirements.
    task automatic access(input bit wr, input logic [AW-1:0] addr, input logic [NL-1:0] be,
                          input logic [DW-1:0] wd, input int wt, input bit relax,
                          input bit setup, input bit ext, input bit early, input int ack_at);
        int w_tot, first_exp, strb_exp, cs_exp, done_exp, term_idx;
        int ale_cnt, first_cs, cs_cnt, oe_cnt, rdy_cnt, done_idx, wbad, adbad;
        int lane_cnt [NL];
        w_tot     = relax ? 2 * wt : wt;
        first_exp = 1 + (setup ? (relax ? 2 : 1) : 0);
        strb_exp  = w_tot + 1;
        if (ext && ack_at >= 0) begin
            term_idx = (ack_at + 2 > first_exp) ? ack_at + 2 : first_exp;
            if (term_idx - first_exp + 1 < strb_exp) strb_exp = term_idx - first_exp + 1;
        end
        cs_exp   = strb_exp + ((wr && early) ? 1 : 0);
        done_exp = first_exp + cs_exp;
        ale_cnt = 0; first_cs = -1; cs_cnt = 0; oe_cnt = 0; rdy_cnt = 0;
        done_idx = -1; wbad = 0; adbad = 0;
        foreach (lane_cnt[i]) lane_cnt[i] = 0;

        @(negedge clk);
        cfg_wait = WW'(wt); cfg_relax = relax; cfg_cs_setup = setup;
        cfg_ext_ack = ext; cfg_we_early = early;
        req_write = wr; req_addr = addr; req_be = be; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 90; k++) begin
            if (ale) begin
                ale_cnt++;
                if (k == 0 && !(ad_oe && ad_out == DW'(addr))) adbad++;
            end
            if (!cs_n) begin
                cs_cnt++;
                if (first_cs < 0) first_cs = k;
            end
            if (!oe_n) oe_cnt++;
            for (int i = 0; i < NL; i++) if (!we_n[i]) lane_cnt[i]++;
            if (wr && k > 0 && !done && !(ad_oe && ad_out == wd)) wbad++;
            if (!wr && k > 0 && ad_oe) wbad++;
            if (done) begin
                done_idx = k;
                break;
            end
            if (req_ready) rdy_cnt++;
            ad_in = pat(k);
            if (k == ack_at) ack_in = 1'b1;
            @(negedge clk);
        end
        chk("R2 ale count", ale_cnt == 1, ale_cnt, 1);
        chk("R2 address on bus", adbad == 0, adbad, 0);
        chk("R3 first cs cycle", first_cs == first_exp, first_cs, first_exp);
        chk("R9 cs low cycles", cs_cnt == cs_exp, cs_cnt, cs_exp);
        chk("R10 done cycle", done_idx == done_exp, done_idx, done_exp);
        chk("R11 busy during access", rdy_cnt == 0, rdy_cnt, 0);
        if (wr) begin
            chk("R6 oe idle on write", oe_cnt == 0, oe_cnt, 0);
            chk("R6 write data on bus", wbad == 0, wbad, 0);
            for (int i = 0; i < NL; i++)
                chk("R6 lane strobe length", lane_cnt[i] == (be[i] ? strb_exp : 0),
                    lane_cnt[i], be[i] ? strb_exp : 0);
        end else begin
            chk("R4 R7 R8 oe strobe length", oe_cnt == strb_exp, oe_cnt, strb_exp);
            chk("R5 bus released on read", wbad == 0, wbad, 0);
            for (int i = 0; i < NL; i++)
                chk("R5 we idle on read", lane_cnt[i] == 0, lane_cnt[i], 0);
            chk("R10 read capture", rd_data == pat(first_exp + strb_exp - 1),
                rd_data, pat(first_exp + strb_exp - 1));
        end
        @(negedge clk);
        chk("R10 done single cycle", done == 1'b0, done, 0);
        ack_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 cs_n", cs_n == 1'b1, cs_n, 1);
        chk("R1 oe_n", oe_n == 1'b1, oe_n, 1);
        chk("R1 we_n", we_n == '1, we_n, 4'hF);
        chk("R1 ale", ale == 1'b0, ale, 0);
        chk("R1 ad_oe", ad_oe == 1'b0, ad_oe, 0);
        chk("R1 done", done == 1'b0, done, 0);
        chk("R1 ready", req_ready == 1'b1, req_ready, 1);
    endtask

    task automatic t_read_basic;        access(0, 16'h1234, 4'hF, '0, 3, 0, 0, 0, 0, -1); endtask
    task automatic t_write_lanes;       access(1, 16'h00A5, 4'b1010, 32'hDEAD_BEEF, 2, 0, 1, 0, 0, -1); endtask
    task automatic t_read_max_R4;       access(0, 16'hFFFF, 4'hF, '0, 15, 1, 1, 0, 0, -1); endtask
    task automatic t_read_zero_wait;    access(0, 16'h0001, 4'hF, '0, 0, 0, 0, 0, 0, -1); endtask
    task automatic t_ack_early_R7;      access(0, 16'h0200, 4'hF, '0, 10, 0, 0, 1, 0, 3); endtask
    task automatic t_ack_late_R7;       access(0, 16'h0300, 4'hF, '0, 5, 0, 0, 1, 0, 20); endtask
    task automatic t_ack_off_R8;        access(0, 16'h0400, 4'hF, '0, 6, 0, 0, 0, 0, 2); endtask
    task automatic t_we_early_R9;       access(1, 16'h0500, 4'hF, 32'h1357_9BDF, 1, 0, 0, 0, 1, -1); endtask
    task automatic t_read_early_bit_R9; access(0, 16'h0600, 4'hF, '0, 2, 0, 0, 0, 1, -1); endtask
    task automatic t_ack_pre_strobe_R7; access(0, 16'h0700, 4'hF, '0, 4, 1, 1, 1, 0, 0); endtask
    task automatic t_write_ack_R7;      access(1, 16'h0800, 4'b0110, 32'h0F0F_F0F0, 8, 1, 0, 1, 1, 4); endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0;
        req_wdata = '0; ack_in = 1'b0; ad_in = '0; cfg_wait = '0; cfg_relax = 1'b0;
        cfg_cs_setup = 1'b0; cfg_ext_ack = 1'b0; cfg_we_early = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_read_basic;
        t_write_lanes;
        t_read_max_R4;
        t_read_zero_wait;
        t_ack_early_R7;
        t_ack_late_R7;
        t_ack_off_R8;
        t_we_early_R9;
        t_read_early_bit_R9;
        t_ack_pre_strobe_R7;
        t_write_ack_R7;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule